// File: doc/BRIEF.md
# Periodic Interrupt Timer with Status Register

This block produces a steady interrupt from a slow oscillator. A 15-bit counter advances once for every cycle on which the oscillator tick enable is high. The tick is a single-cycle pulse in the system clock domain, taken from a 32.768 kHz source. A build-time parameter selects the interrupt period:

| `PERIOD_SEL` | Period | Ticks per period |
|---|---|---|
| 0 | 0.25 s | 8192 |
| 1 | 0.5 s | 16384 |
| 2 | 1 s | 32768 |

When the counter completes a period, the block sets a sticky flag.

Software reaches the block through one 8-bit control/status register on a plain CPU bus. The bus has an address, write data, a write strobe and combinational read data. Software clears the flag by writing a zero to the flag bit. It enables the request output through the enable bit. The active-high interrupt line is high whenever both the flag and the enable are set. The counter never stops and never restarts, so interrupts keep a fixed cadence whatever software does.

Top module: `pit_timer`

## Requirements
- R1: While reset is asserted, and after it is released, the flag and the enable are 0, the register reads 0x00 and the interrupt output is 0.
- R2: The flag sets on the tick that completes each period. With `PERIOD_SEL` 0, 1 and 2, that is after 8192, 16384 and 32768 ticks from reset. It is still clear one tick earlier. With `PERIOD_SEL` 2, the event is the 15-bit counter wrapping from 0x7FFF to 0x0000.
- R3: The counter advances only on cycles with the tick enable high. Cycles without a tick do not move the period boundary.
- R4: Once set, the flag stays set across later ticks and period boundaries until software clears it.
- R5: The register is at address 0x12, with the flag at bit 7. A write with bit 7 = 0 clears the flag. A write with bit 7 = 1 leaves the flag unchanged, whether it was 0 or 1.
- R6: The enable is read/write at bit 6. The interrupt output is 1 exactly when the flag and the enable are both 1. With the enable at 0, the flag still sets but the output stays 0.
- R7: Reads of 0x12 return the flag at bit 7, the enable at bit 6, and 0 in bits 5..0 even after ones are written there. Reads of any other address return 0x00. Writes to any other address change nothing.
- R8: If a period event and a clearing write fall in the same cycle, the flag ends up set.
- R9: Register writes never touch the counter. A flag cleared in mid-period sets again on the original schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| oscTick | input | 1 | One-cycle pulse per oscillator period (32.768 kHz) |
| busAddr | input | 8 | Register address |
| busWrData | input | 8 | Write data |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busRdData | output | 8 | Combinational read data for `busAddr` |
| irq | output | 1 | Active-high interrupt request |

## Verification
The bench counts ticks from reset and checks the flag one tick before each expected boundary and again on the boundary itself. An off-by-one tap, or a counter that moves on idle cycles, would show up as a flag that arrives early or late. It writes a one to the flag bit both while the flag is clear and while it is set, so logic that copies bit 7 into the flag would be exposed. It lines up a clearing write with the very tick that ends a period, so a design that favours the clear would lose that interrupt. It also clears in mid-period and expects the next flag on the original schedule, which a design that restarts the counter on writes would miss.

// File: rtl/pit_pkg.sv
package pit_pkg;

  localparam int CNT_W    = 15;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 8;
  localparam int FLAG_BIT = 7;
  localparam int EN_BIT   = 6;

  // Strobes handed from bus control to the status register
  typedef struct packed {
    logic csrWrite;   // write hit on the control/status register
    logic clearFlag;  // write hit with a zero in the flag position
    logic enValue;    // enable value carried by the write
  } pitStrobes_t;

endpackage

// File: rtl/pit_divider.sv
module pit_divider
  import pit_pkg::*;
#(
  parameter int TAP_BIT = 14
) (
  input  logic clk,
  input  logic rstN,
  input  logic oscTick,
  output logic periodEvt
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        cnt <= '0;
    else if (oscTick) cnt <= cnt + 1'b1;
  end

  // A period ends when the low TAP_BIT+1 bits are about to roll over
  assign periodEvt = oscTick && (&cnt[TAP_BIT:0]);

  // R2
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (oscTick && (cnt == {CNT_W{1'b1}})) |=> (cnt == '0));

  // R2
  evt_rolls_sub_chk: assert property (@(posedge clk) disable iff (!rstN)
    periodEvt |=> (cnt[TAP_BIT:0] == '0));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !oscTick |=> $stable(cnt));

endmodule

// File: rtl/pit_status_reg.sv
module pit_status_reg
  import pit_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  pitStrobes_t strobes,
  input  logic        periodEvt,
  output logic        flag,
  output logic        enable,
  output logic        irq
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flag   <= 1'b0;
      enable <= 1'b0;
    end else begin
      // the set event outranks a clearing write
      if (periodEvt)              flag <= 1'b1;
      else if (strobes.clearFlag) flag <= 1'b0;
      if (strobes.csrWrite)       enable <= strobes.enValue;
    end
  end

  assign irq = flag & enable;

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    periodEvt |=> flag);

  // R5
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clearFlag && !periodEvt) |=> !flag);

  // R4
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flag && !strobes.clearFlag) |=> flag);

  // R5
  no_soft_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!flag && !periodEvt) |=> !flag);

endmodule

// File: rtl/pit_bus_ctrl.sv
module pit_bus_ctrl
  import pit_pkg::*;
#(
  parameter logic [ADDR_W-1:0] CSR_ADDR = 8'h12
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busWrEn,
  input  logic              flag,
  input  logic              enable,
  output pitStrobes_t       strobes,
  output logic [DATA_W-1:0] busRdData
);

  logic csrHit;
  logic unusedWrBits;

  assign csrHit       = (busAddr == CSR_ADDR);
  assign unusedWrBits = ^busWrData[EN_BIT-1:0];

  always_comb begin
    strobes.csrWrite  = busWrEn && csrHit;
    strobes.clearFlag = busWrEn && csrHit && !busWrData[FLAG_BIT];
    strobes.enValue   = busWrData[EN_BIT];
  end

  always_comb begin
    busRdData = '0;
    if (csrHit) begin
      busRdData[FLAG_BIT] = flag;
      busRdData[EN_BIT]   = enable;
    end
  end

endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
#(
  parameter int                PERIOD_SEL = 2,
  parameter logic [ADDR_W-1:0] CSR_ADDR   = 8'h12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              oscTick,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busWrEn,
  output logic [DATA_W-1:0] busRdData,
  output logic              irq
);

  localparam int TAP_BIT = (PERIOD_SEL == 0) ? CNT_W - 3 :
                           (PERIOD_SEL == 1) ? CNT_W - 2 : CNT_W - 1;

  pitStrobes_t strobes;
  logic        periodEvt;
  logic        flag;
  logic        enable;

  pit_divider #(.TAP_BIT(TAP_BIT)) u_divider (
    .clk       (clk),
    .rstN      (rstN),
    .oscTick   (oscTick),
    .periodEvt (periodEvt)
  );

  pit_bus_ctrl #(.CSR_ADDR(CSR_ADDR)) u_bus_ctrl (
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .busWrEn   (busWrEn),
    .flag      (flag),
    .enable    (enable),
    .strobes   (strobes),
    .busRdData (busRdData)
  );

  pit_status_reg u_status (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .periodEvt (periodEvt),
    .flag      (flag),
    .enable    (enable),
    .irq       (irq)
  );

endmodule

// File: tb/pit_timer_bench.sv
module pit_timer_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       oscTick = 1'b0;
  logic [7:0] busAddr = 8'h12;
  logic [7:0] busWrData = 8'h00;
  logic       busWrEn = 1'b0;
  logic [7:0] rdMain, rdQ;
  logic       irqMain, irqQ;

  int checks = 0;
  int errors = 0;
  int ticks  = 0;

  always #10 clk = ~clk;

  pit_timer u_pit_timer (
    .clk(clk), .rstN(rstN), .oscTick(oscTick), .busAddr(busAddr),
    .busWrData(busWrData), .busWrEn(busWrEn), .busRdData(rdMain), .irq(irqMain)
  );

  pit_timer #(.PERIOD_SEL(0)) u_pit_timer_q (
    .clk(clk), .rstN(rstN), .oscTick(oscTick), .busAddr(busAddr),
    .busWrData(busWrData), .busWrEn(busWrEn), .busRdData(rdQ), .irq(irqQ)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h (ticks=%0d)", req, act, exp, ticks);
    end
  endtask

  task automatic runTicks(input int n);
    for (int i = 0; i < n; i++) begin
      oscTick = 1'b1;
      @(negedge clk);
      oscTick = 1'b0;
      ticks++;
    end
  endtask

  task automatic busWrite(input logic [7:0] addr, input logic [7:0] data, input logic withTick);
    busAddr = addr; busWrData = data; busWrEn = 1'b1; oscTick = withTick;
    @(negedge clk);
    busWrEn = 1'b0; oscTick = 1'b0; busAddr = 8'h12;
    if (withTick) ticks++;
    #1;
  endtask

  task automatic testReset();
    check("R1 main read", rdMain, 8'h00);
    check("R1 quarter read", rdQ, 8'h00);
    check("R1 main irq", {7'b0, irqMain}, 8'h00);
    check("R1 quarter irq", {7'b0, irqQ}, 8'h00);
  endtask

  task automatic testQuarterPeriod();
    runTicks(8191);
    check("R2 quarter before boundary", rdQ, 8'h00);
    runTicks(1);
    check("R2 quarter on boundary", rdQ, 8'h80);
    check("R2 main not yet", rdMain, 8'h00);
    repeat (50) @(negedge clk);  // idle cycles, no ticks (R3)
  endtask

  task automatic testEnable();
    busWrite(8'h12, 8'hC0, 1'b0);
    check("R6 quarter read with enable", rdQ, 8'hC0);
    check("R6 quarter irq high", {7'b0, irqQ}, 8'h01);
    check("R6 main irq low, flag clear", {7'b0, irqMain}, 8'h00);
    check("R5 one-write no set main", rdMain, 8'h40);
    busWrite(8'h12, 8'h80, 1'b0);
    check("R6 enable off keeps flag", rdQ, 8'h80);
    check("R6 quarter irq low", {7'b0, irqQ}, 8'h00);
  endtask

  task automatic testOtherBits();
    busWrite(8'h13, 8'h00, 1'b0);
    check("R7 foreign write ignored", rdQ, 8'h80);
    busAddr = 8'h13; #1;
    check("R7 foreign read zero", rdQ, 8'h00);
    busAddr = 8'h12; #1;
    busWrite(8'h12, 8'hFF, 1'b0);
    check("R7 low bits read zero", rdQ, 8'hC0);
    busWrite(8'h12, 8'h80, 1'b0);
  endtask

  task automatic testClear();
    busWrite(8'h12, 8'h00, 1'b0);
    check("R5 zero write clears", rdQ, 8'h00);
    busWrite(8'h12, 8'h80, 1'b0);
    check("R5 one write leaves clear", rdQ, 8'h00);
  endtask

  task automatic testFullPeriod();
    runTicks(32767 - ticks);
    check("R2 main before wrap", rdMain, 8'h00);
    check("R4 quarter sticky over periods", rdQ, 8'h80);
    runTicks(1);
    check("R2 main on wrap", rdMain, 8'h80);
    check("R6 flag sets with enable off", {7'b0, irqMain}, 8'h00);
    busWrite(8'h12, 8'hC0, 1'b0);
    check("R6 main irq once enabled", {7'b0, irqMain}, 8'h01);
    check("R5 one-write keeps set flag", rdMain, 8'hC0);
  endtask

  task automatic testSetWins();
    busWrite(8'h12, 8'h40, 1'b0);
    check("R5 clear main", rdMain, 8'h40);
    runTicks(40959 - ticks);
    check("R2 quarter before boundary again", rdQ, 8'h40);
    busWrite(8'h12, 8'h40, 1'b1);
    check("R8 set beats clear", rdQ, 8'hC0);
    check("R8 irq raised", {7'b0, irqQ}, 8'h01);
    check("R8 main cleared", rdMain, 8'h40);
  endtask

  task automatic testCounterUntouched();
    busWrite(8'h12, 8'h40, 1'b0);
    runTicks(2000);
    busWrite(8'h12, 8'h40, 1'b0);
    runTicks(49151 - ticks);
    check("R9 no early flag", rdQ, 8'h40);
    runTicks(1);
    check("R9 flag on original schedule", rdQ, 8'hC0);
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 during reset", rdMain, 8'h00);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    testReset();
    testQuarterPeriod();
    testEnable();
    testOtherBits();
    testClear();
    testFullPeriod();
    testSetWins();
    testCounterUntouched();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule